// File: doc/BRIEF.md
# LCD Common/Segment Scan Controller

This block drives a dot-matrix liquid crystal panel of 8 commons by 40 segments (320 dots) from a nibble-wide display memory. Software picks a display mode by writing a 4-bit control register through a single-cycle write strobe. A programmable prescaler divides the system clock into common periods. The scan visits the commons in ascending order, one per period, and wraps after the last one. While a common is shown, the sequencer reads the ten nibbles of the next common's row from display RAM. It assembles them into a 40-bit staging register, and that register moves to the visible register at the period boundary. The panel therefore never shows a half-loaded row.

Every COM and SEG pin is presented as a 2-bit level code for an external analog bias stage. Code 00 is ground, 01 is the non-selected level, and 1f is the selected level, where f is the frame-polarity bit. The frame-polarity bit flips each time the scan wraps back to the first common. A power-enable latch gates the whole output stage. The latch sets the first time the enable mode is written. After that it stays on through any later mode write, and only reset or a sleep request clears it. A blanking mode idles every common while the segment pins keep presenting the display data.

The prescale value must be at least 11, so that the row fetch completes inside one common period.

Top module: `lcd_scan_top`

## Requirements
- R1: After reset, powerEn is 0, every COM and SEG code is 00, the mode is "off", and the first row fetched is common 0.
- R2: Bits 3:2 of a register write select the mode (00 off, 01 blank, 10 reserved, 11 enable). Bits 1:0 have no effect. A write takes effect on the clock edge that samples regWrEn.
- R3: powerEn rises only on a write whose mode field is 11. Once set, it stays set through later writes of any mode.
- R4: While sleepReq is high, powerEn and the mode are cleared, and writes made during sleep are discarded. After sleep, a write of mode 00 or 01 leaves powerEn at 0; only mode 11 sets it again.
- R5: While powerEn is 0, every COM and SEG code is 00, whatever the mode.
- R6: With power on and mode 11, exactly one common carries code {1,f} and the others carry 01. Segment s carries {1,f} when its display bit is 1, and 01 when it is 0.
- R7: With power on and mode 01, every COM code is 01, and the SEG codes present the display data exactly as in R6.
- R8: With power on and mode 00 or the reserved mode 10, every COM and SEG code is 01.
- R9: A common period lasts prescaleDiv+1 clock cycles. The commons advance 0,1,…,7,0. The frame bit f flips on each wrap to common 0 and is 0 in the first frame after reset.
- R10: For common c, the block issues the reads 0x20+16·c+n for n = 0..9, in ascending n, one per cycle. Read data is taken one cycle after its read. Segment 4·n+b shows bit b of nibble n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleepReq | input | 1 | High while the system is asleep; clears power and mode |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 4 | Write data; bits 3:2 are the mode field |
| prescaleDiv | input | 16 | Common period length minus one (≥ 11) |
| ramRdEn | output | 1 | Display RAM read request |
| ramRdAddr | output | 8 | Display RAM nibble address |
| ramRdData | input | 4 | Read data, valid the cycle after ramRdEn |
| comLevel | output | 16 | Level code per common, common k on bits 2k+1:2k |
| segLevel | output | 80 | Level code per segment, segment s on bits 2s+1:2s |
| powerEn | output | 1 | LCD power-switch enable |

## Verification
A vector table walks mode writes through every code. Each code is written both with bits 1:0 clear and with them set, and the writes come both before and after the power latch sets. This separates "power off dominates" from "mode decode" and shows that the low bits are ignored. Sleep pulses, writes made during sleep, and a mid-run reset then show that the latch clears only through those two routes, and that writes of 00 or 01 after wake do not restore it. Display RAM holds a pattern that differs per common and per nibble. As a result, a wrong row, a wrong nibble order or a wrong bit order within a nibble produces a segment mismatch. A running tracker compares every read address against the expected ascending sequence. A directed scan test measures the period length, the order of the commons and the frame-bit flip at each wrap.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int SEG_N    = 40;
  localparam int COM_N    = 8;
  localparam int NIB_W    = 4;
  localparam int NIB_N    = SEG_N / NIB_W;
  localparam int NIBIDX_W = $clog2(NIB_N + 1);
  localparam int COMIDX_W = $clog2(COM_N);
  localparam int LVL_W    = 2;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_BLANK = 2'b01,
    MODE_RSVD  = 2'b10,
    MODE_ON    = 2'b11
  } lcd_mode_e;

  localparam logic [LVL_W-1:0] LVL_GND  = 2'b00;
  localparam logic [LVL_W-1:0] LVL_IDLE = 2'b01;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic                showLoad;
    logic                rdIssue;
    logic [NIBIDX_W-1:0] rdNib;
    logic [COMIDX_W-1:0] comIdx;
    logic                frameInv;
    lcd_mode_e           mode;
    logic                powerOn;
  } lcd_ctrl_t;
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int                PRESC_W    = 16,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h20,
  parameter int                ROW_STRIDE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleepReq,
  input  logic               regWrEn,
  input  logic [3:0]         regWrData,
  input  logic [PRESC_W-1:0] prescaleDiv,
  output logic               ramRdEn,
  output logic [ADDR_W-1:0]  ramRdAddr,
  output lcd_ctrl_t          ctrl
);
  localparam logic [COMIDX_W-1:0] LAST_COM = COMIDX_W'(COM_N - 1);
  localparam logic [NIBIDX_W-1:0] LAST_NIB = NIBIDX_W'(NIB_N - 1);

  lcd_mode_e           modeQ;
  logic                powerQ;
  logic [PRESC_W-1:0]  prescCnt;
  logic                tick;
  logic [COMIDX_W-1:0] comIdx;
  logic                frameInv;
  logic                fetchActive;
  logic [NIBIDX_W-1:0] fetchNib;
  logic [COMIDX_W-1:0] fetchCom;

  // mode register and sticky power latch
  always_ff @(posedge clk) begin
    if (!rst_n || sleepReq) begin
      modeQ  <= MODE_OFF;
      powerQ <= 1'b0;
    end else if (regWrEn) begin
      modeQ <= lcd_mode_e'(regWrData[3:2]);
      if (regWrData[3:2] == MODE_ON) powerQ <= 1'b1;
    end
  end

  // common period prescaler
  assign tick = (prescCnt == prescaleDiv);

  always_ff @(posedge clk) begin
    if (!rst_n)    prescCnt <= '0;
    else if (tick) prescCnt <= '0;
    else           prescCnt <= prescCnt + 1'b1;
  end

  // common index and frame polarity
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comIdx   <= LAST_COM;
      frameInv <= 1'b1;
    end else if (tick) begin
      if (comIdx == LAST_COM) begin
        comIdx   <= '0;
        frameInv <= ~frameInv;
      end else begin
        comIdx <= comIdx + 1'b1;
      end
    end
  end

  // row fetch for the next common
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetchActive <= 1'b1;
      fetchNib    <= '0;
    end else if (tick) begin
      fetchActive <= 1'b1;
      fetchNib    <= '0;
    end else if (fetchActive) begin
      if (fetchNib == LAST_NIB) fetchActive <= 1'b0;
      fetchNib <= fetchNib + 1'b1;
    end
  end

  assign fetchCom  = (comIdx == LAST_COM) ? '0 : comIdx + 1'b1;
  assign ramRdEn   = fetchActive;
  assign ramRdAddr = BASE_ADDR + ADDR_W'(fetchCom) * ADDR_W'(ROW_STRIDE) + ADDR_W'(fetchNib);

  always_comb begin
    ctrl.showLoad = tick;
    ctrl.rdIssue  = fetchActive;
    ctrl.rdNib    = fetchNib;
    ctrl.comIdx   = comIdx;
    ctrl.frameInv = frameInv;
    ctrl.mode     = modeQ;
    ctrl.powerOn  = powerQ;
  end
endmodule

// File: rtl/lcd_scan_dp.sv
module lcd_scan_dp
  import lcd_scan_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  lcd_ctrl_t              ctrl,
  input  logic [NIB_W-1:0]       ramRdData,
  output logic [COM_N*LVL_W-1:0] comLevel,
  output logic [SEG_N*LVL_W-1:0] segLevel
);
  logic                rdValid;
  logic [NIBIDX_W-1:0] rdNibQ;
  logic [SEG_N-1:0]    segFetch;
  logic [SEG_N-1:0]    segShow;
  logic [LVL_W-1:0]    selCode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      rdNibQ  <= '0;
    end else begin
      rdValid <= ctrl.rdIssue;
      rdNibQ  <= ctrl.rdNib;
    end
  end

  // staging register filled nibble by nibble
  always_ff @(posedge clk) begin
    if (!rst_n)       segFetch <= '0;
    else if (rdValid) segFetch[int'(rdNibQ)*NIB_W +: NIB_W] <= ramRdData;
  end

  // visible register swaps only at a common boundary
  always_ff @(posedge clk) begin
    if (!rst_n)             segShow <= '0;
    else if (ctrl.showLoad) segShow <= segFetch;
  end

  assign selCode = {1'b1, ctrl.frameInv};

  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    always_comb begin
      if (!ctrl.powerOn)
        segLevel[s*LVL_W +: LVL_W] = LVL_GND;
      else if (ctrl.mode == MODE_ON || ctrl.mode == MODE_BLANK)
        segLevel[s*LVL_W +: LVL_W] = segShow[s] ? selCode : LVL_IDLE;
      else
        segLevel[s*LVL_W +: LVL_W] = LVL_IDLE;
    end
  end

  for (genvar c = 0; c < COM_N; c++) begin : g_com
    always_comb begin
      if (!ctrl.powerOn)
        comLevel[c*LVL_W +: LVL_W] = LVL_GND;
      else if (ctrl.mode == MODE_ON && ctrl.comIdx == COMIDX_W'(c))
        comLevel[c*LVL_W +: LVL_W] = selCode;
      else
        comLevel[c*LVL_W +: LVL_W] = LVL_IDLE;
    end
  end
endmodule

// File: rtl/lcd_scan_top.sv
module lcd_scan_top
  import lcd_scan_pkg::*;
#(
  parameter int                PRESC_W    = 16,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h20,
  parameter int                ROW_STRIDE = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sleepReq,
  input  logic                   regWrEn,
  input  logic [3:0]             regWrData,
  input  logic [PRESC_W-1:0]     prescaleDiv,
  output logic                   ramRdEn,
  output logic [ADDR_W-1:0]      ramRdAddr,
  input  logic [NIB_W-1:0]       ramRdData,
  output logic [COM_N*LVL_W-1:0] comLevel,
  output logic [SEG_N*LVL_W-1:0] segLevel,
  output logic                   powerEn
);
  lcd_ctrl_t ctrl;

  lcd_scan_ctrl #(
    .PRESC_W(PRESC_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ROW_STRIDE(ROW_STRIDE)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .regWrEn(regWrEn),
    .regWrData(regWrData), .prescaleDiv(prescaleDiv), .ramRdEn(ramRdEn),
    .ramRdAddr(ramRdAddr), .ctrl(ctrl)
  );

  lcd_scan_dp dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ramRdData(ramRdData),
    .comLevel(comLevel), .segLevel(segLevel)
  );

  assign powerEn = ctrl.powerOn;
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk
  import lcd_scan_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sleepReq,
  input logic                   regWrEn,
  input logic [3:0]             regWrData,
  input logic                   ramRdEn,
  input logic [ADDR_W-1:0]      ramRdAddr,
  input logic [COM_N*LVL_W-1:0] comLevel,
  input logic [SEG_N*LVL_W-1:0] segLevel,
  input logic                   powerEn
);
  logic [COM_N-1:0] comSelBits;
  for (genvar i = 0; i < COM_N; i++) begin : g_sel
    assign comSelBits[i] = comLevel[i*LVL_W + 1];
  end

  AST_GROUND_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !powerEn |-> (comLevel == '0 && segLevel == '0)); // R5
  AST_POWER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (powerEn && !sleepReq) |=> powerEn); // R3
  AST_POWER_ONLY_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powerEn) |-> $past(regWrEn && regWrData[3:2] == 2'b11 && !sleepReq)); // R3
  AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sleepReq |=> !powerEn); // R4
  AST_SINGLE_COMMON: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comSelBits)); // R6
  AST_READ_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    ramRdEn |-> (ramRdAddr[3:0] < 4'(NIB_N))); // R10
endmodule

bind lcd_scan_top lcd_scan_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .regWrEn(regWrEn),
  .regWrData(regWrData), .ramRdEn(ramRdEn), .ramRdAddr(ramRdAddr),
  .comLevel(comLevel), .segLevel(segLevel), .powerEn(powerEn)
);

// File: tb/lcd_scan_top_tb.sv
module lcd_scan_top_tb_top;
  import lcd_scan_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleepReq = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regWrData = '0;
  logic [15:0] prescaleDiv = 16'd15;
  logic        ramRdEn;
  logic [7:0]  ramRdAddr;
  logic [3:0]  ramRdData = '0;
  logic [15:0] comLevel;
  logic [79:0] segLevel;
  logic        powerEn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  lcd_scan_top dut_i (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .regWrEn(regWrEn),
    .regWrData(regWrData), .prescaleDiv(prescaleDiv), .ramRdEn(ramRdEn),
    .ramRdAddr(ramRdAddr), .ramRdData(ramRdData), .comLevel(comLevel),
    .segLevel(segLevel), .powerEn(powerEn)
  );

  function automatic logic [3:0] memVal(input int a);
    return 4'((a / 16) * 3 + (a % 16) * 5 + 1);
  endfunction

  function automatic bit dataBit(input int c, input int s);
    logic [3:0] n;
    n = memVal(32 + 16 * c + s / 4);
    return n[s % 4];
  endfunction

  // display RAM model, one cycle read latency
  logic       pendEn = 1'b0;
  logic [7:0] pendAddr = '0;
  int expCom = 0, expNib = 0;
  always @(negedge clk) begin
    pendEn   <= ramRdEn;
    pendAddr <= ramRdAddr;
    if (!rst_n) begin
      expCom = 0; expNib = 0;
    end else if (ramRdEn) begin
      nChecks++;
      if (int'(ramRdAddr) != 32 + 16 * expCom + expNib) begin
        nFails++;
        $display("FAIL R10 read address act=%h exp=%h", ramRdAddr, 32 + 16 * expCom + expNib);
      end
      expNib++;
      if (expNib == NIB_N) begin expNib = 0; expCom = (expCom + 1) % COM_N; end
    end
  end
  always @(posedge clk) if (pendEn) ramRdData <= memVal(int'(pendAddr));

  // segments match row c; anyF accepts either polarity
  function automatic bit segRowOk(input int c, input bit fr, input bit anyF);
    for (int s = 0; s < SEG_N; s++) begin
      logic [1:0] code;
      code = segLevel[2*s +: 2];
      if (dataBit(c, s)) begin
        if (code[1] != 1'b1 || (!anyF && code[0] != fr)) return 1'b0;
      end else if (code != 2'b01) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic getSel(output int c, output bit fr, output int nSel);
    c = -1; fr = 1'b0; nSel = 0;
    for (int k = 0; k < COM_N; k++)
      if (comLevel[2*k+1]) begin c = k; fr = comLevel[2*k]; nSel++; end
  endtask

  task automatic check(input bit ok, input string req, input string what);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s act com=%h seg=%h pwr=%b", req, what, comLevel, segLevel, powerEn);
    end
  endtask

  // cls: 0 ground, 1 all idle, 2 blank, 3 normal
  task automatic checkState(input bit expPow, input int cls, input string req);
    bit ok; int c, nSel; bit fr;
    nChecks++;
    if (powerEn != expPow) begin
      nFails++;
      $display("FAIL %s powerEn act=%b exp=%b", req, powerEn, expPow);
    end
    ok = 1'b1;
    case (cls)
      0: ok = (comLevel == '0) && (segLevel == '0);
      1: ok = (comLevel == {COM_N{2'b01}}) && (segLevel == {SEG_N{2'b01}});
      2: begin
        ok = (comLevel == {COM_N{2'b01}});
        if (ok) begin
          ok = 1'b0;
          for (int k = 0; k < COM_N; k++) if (segRowOk(k, 1'b0, 1'b1)) ok = 1'b1;
        end
      end
      default: begin
        getSel(c, fr, nSel);
        ok = (nSel == 1);
        for (int k = 0; k < COM_N; k++)
          if (ok && k != c && comLevel[2*k +: 2] != 2'b01) ok = 1'b0;
        if (ok) ok = segRowOk(c, fr, 1'b0);
      end
    endcase
    check(ok, req, $sformatf("output class exp=%0d", cls));
  endtask

  task automatic writeReg(input logic [3:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic sleepPulse(input int n);
    @(negedge clk); sleepReq = 1'b1;
    repeat (n) @(negedge clk);
    sleepReq = 1'b0;
  endtask

  // op: 0 write, 1 sleep pulse
  typedef struct packed {
    logic [1:0] op;
    logic [3:0] data;
    logic       pw;
    logic [1:0] cls;
  } vec_t;
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'h4, 1'b0, 2'd0},  // R5 blank without power
    '{2'd0, 4'h8, 1'b0, 2'd0},  // R5 reserved without power
    '{2'd0, 4'hC, 1'b1, 2'd3},  // R3 enable
    '{2'd0, 4'h0, 1'b1, 2'd1},  // R8 off, latch holds
    '{2'd0, 4'h7, 1'b1, 2'd2},  // R2 low bits ignored, blank
    '{2'd0, 4'hB, 1'b1, 2'd1},  // R8 reserved acts as off
    '{2'd0, 4'hF, 1'b1, 2'd3},  // R6 enable again
    '{2'd0, 4'h4, 1'b1, 2'd2},  // R7 blank
    '{2'd1, 4'h0, 1'b0, 2'd0},  // R4 sleep
    '{2'd0, 4'h4, 1'b0, 2'd0},  // R4 blank after wake
    '{2'd0, 4'hD, 1'b1, 2'd3},  // R4 re-enable
    '{2'd0, 4'h1, 1'b1, 2'd1}   // R2 mode 00 with low bit set
  };

  function automatic string clsReq(input int cls);
    case (cls)
      0: return "R5";
      1: return "R8";
      2: return "R7";
      default: return "R6";
    endcase
  endfunction

  initial begin
    int c0, c1, nSel, len; bit f0, f1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkState(1'b0, 0, "R1");
    repeat (40) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op == 2'd1) sleepPulse(3);
      else writeReg(VEC[i].data);
      checkState(VEC[i].pw, int'(VEC[i].cls), clsReq(int'(VEC[i].cls)));
      repeat (23) @(negedge clk);
      checkState(VEC[i].pw, int'(VEC[i].cls), "R3");
    end

    // R4: a write made during sleep is discarded
    @(negedge clk); sleepReq = 1'b1; regWrEn = 1'b1; regWrData = 4'hC;
    @(negedge clk); regWrEn = 1'b0;
    @(negedge clk); sleepReq = 1'b0;
    @(negedge clk);
    checkState(1'b0, 0, "R4");

    // R9: period length, common order, frame polarity
    writeReg(4'hC);
    getSel(c0, f0, nSel);
    len = 0;
    while (len < 40) begin
      @(negedge clk); getSel(c1, f1, nSel);
      len++;
      if (c1 != c0) break;
    end
    c0 = c1; f0 = f1;
    for (int p = 0; p < 12; p++) begin
      len = 0;
      while (len < 40) begin
        @(negedge clk); getSel(c1, f1, nSel);
        len++;
        if (c1 != c0) break;
      end
      check(len == int'(prescaleDiv) + 1, "R9", $sformatf("period act=%0d exp=%0d", len, prescaleDiv + 1));
      check(c1 == (c0 + 1) % COM_N, "R9", $sformatf("order act=%0d exp=%0d", c1, (c0 + 1) % COM_N));
      check(f1 == (f0 ^ (c1 == 0)), "R9", $sformatf("frame act=%0d exp=%0d", f1, f0 ^ (c1 == 0)));
      checkState(1'b1, 3, "R10");
      c0 = c1; f0 = f1;
    end

    // R1: reset clears the latch, then blank stays grounded
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk); rst_n = 1'b1;
    checkState(1'b0, 0, "R1");
    writeReg(4'h4);
    checkState(1'b0, 0, "R1");

    // R9: first frame after reset has frame bit 0 on common 0
    writeReg(4'hC);
    repeat (20) @(negedge clk);
    getSel(c1, f1, nSel);
    check(c1 == 0 && f1 == 1'b0, "R9", $sformatf("first com/frame act=%0d/%0d exp=0/0", c1, f1));
    checkState(1'b1, 3, "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule